// File: doc/BRIEF.md
# Load/Store Data Formatter

This block sits between a 32-bit register file and a 64-bit little-endian memory data port with eight byte lanes. For a store it takes one register value, or an even/odd register pair, and produces the write data and byte enables for the addressed lanes. For a load it takes the 64-bit read word and returns the destination register value, or two register values for a pair load. Loaded data is sign-extended, zero-extended or placed in the upper half of the register, depending on the access type. Address generation and memory timing are handled elsewhere. The block only sees the three low address bits and a 3-bit access-type code.

Requests enter on a valid/ready handshake. Each accepted request produces one formatted result on a valid/ready output one clock cycle later. The output stage is a single register. `req_ready` is high whenever that register is empty or its content is being taken in the same cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and no new request is accepted. A source must keep its request stable until it is accepted.

Access-type codes are:

| Code | Access |
|------|--------|
| 0 | signed byte |
| 1 | unsigned byte |
| 2 | signed halfword |
| 3 | unsigned halfword |
| 4 | fractional (Q) halfword |
| 5 | word |
| 6 | doubleword register pair |
| 7 | reserved |

Top module: `lsf_formatter`

## Requirements
- R1: Code 0 or 1 load: the read byte at lane `req_addr_lo` is returned in `rsp_ld_lo`. Code 0 sign-extends it to 32 bits and code 1 zero-extends it.
- R2: Code 2 or 3 load: the halfword in lanes `req_addr_lo` (low byte) and `req_addr_lo`+1 (high byte) is returned. Code 2 sign-extends it and code 3 zero-extends it.
- R3: Code 4 load: the addressed halfword is returned in `rsp_ld_lo[31:16]`, and `rsp_ld_lo[15:0]` is zero.
- R4: Code 5 load returns the four bytes starting at lane `req_addr_lo` in `rsp_ld_lo`. Code 6 load returns lanes 0-3 in `rsp_ld_lo` (register n) and lanes 4-7 in `rsp_ld_hi` (register n+1).
- R5: Code 0/1, 2/3 and 5 stores use only the low 8, 16 or 32 bits of `req_wdata_lo`. Those bits are repeated across all eight lanes of `rsp_wdata`. `rsp_be` has exactly 1, 2 or 4 bits set, starting at bit `req_addr_lo`.
- R6: Code 4 store writes `req_wdata_lo[31:16]` as a halfword, repeated on every lane pair, with two enables starting at `req_addr_lo`.
- R7: Code 6 store sets all eight enables. `req_wdata_lo` (register n) goes on lanes 0-3 and `req_wdata_hi` (register n+1) on lanes 4-7.
- R8: Any of the following sets `rsp_err`, forces `rsp_be`, `rsp_wdata`, `rsp_ld_lo` and `rsp_ld_hi` to zero, and is otherwise handled like any other request:
  - a halfword access (codes 2-4) at an odd address;
  - a word access at an address not a multiple of 4;
  - a doubleword access at a non-zero address;
  - code 7.
- R9: For a load, `rsp_be` marks the lanes read and `rsp_wdata` is zero. `rsp_ld_hi` is zero except for code 6 loads. For a store, `rsp_ld_lo` and `rsp_ld_hi` are zero.
- R10: A request accepted at a clock edge appears on `rsp_valid` at that edge. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, every response output stays stable.
- R11: After reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_is_load | input | 1 | 1 = load, 0 = store |
| req_acc | input | 3 | Access-type code |
| req_addr_lo | input | 3 | Byte offset within the 64-bit data word |
| req_wdata_lo | input | 32 | Store source register n |
| req_wdata_hi | input | 32 | Store source register n+1 (pair only) |
| req_rdata | input | 64 | Memory read data for loads |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken this cycle |
| rsp_be | output | 8 | Byte-lane enables |
| rsp_wdata | output | 64 | Lane-aligned store data |
| rsp_ld_lo | output | 32 | Load result for register n |
| rsp_ld_hi | output | 32 | Load result for register n+1 |
| rsp_err | output | 1 | Misaligned access or reserved code |

## Verification
A wrong lane decode or a wrong extension shows up as a mismatch on `rsp_be`, `rsp_wdata` or the load results. This happens on the very response of the request that triggered it, one cycle after acceptance, because the block holds no state other than the output register. A fault in that register or in the handshake appears in one of three ways:
- a response that changes during a stall;
- a `req_ready` that disagrees with the output state;
- a missing or extra response, which the bench finds as soon as the next result is compared in order.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  typedef enum logic [2:0] {
    ACC_BYTE_S = 3'd0,
    ACC_BYTE_U = 3'd1,
    ACC_HALF_S = 3'd2,
    ACC_HALF_U = 3'd3,
    ACC_QHALF  = 3'd4,
    ACC_WORD   = 3'd5,
    ACC_PAIR   = 3'd6,
    ACC_RSVD   = 3'd7
  } acc_e;

  // Width of one access in bytes; 0 marks an unusable code.
  function automatic int unsigned acc_bytes(acc_e a, int unsigned reg_bytes);
    case (a)
      ACC_BYTE_S, ACC_BYTE_U:            return 1;
      ACC_HALF_S, ACC_HALF_U, ACC_QHALF: return 2;
      ACC_WORD:                          return reg_bytes;
      ACC_PAIR:                          return 2 * reg_bytes;
      default:                           return 0;
    endcase
  endfunction
endpackage

// File: rtl/lsf_lane_ctl.sv
module lsf_lane_ctl
  import lsf_pkg::*;
#(
  parameter int REG_W = 32,
  localparam int BUS_BYTES = 2 * REG_W / 8,
  localparam int OFS_W = $clog2(BUS_BYTES)
) (
  input  acc_e                 acc,
  input  logic [OFS_W-1:0]     ofs,
  output logic [BUS_BYTES-1:0] be,
  output logic                 err
);
  localparam int REG_BYTES = REG_W / 8;

  int unsigned               nbytes;
  logic [BUS_BYTES-1:0]      width_mask;
  logic                      misaligned;

  always_comb begin
    nbytes     = acc_bytes(acc, REG_BYTES);
    width_mask = '0;
    for (int i = 0; i < BUS_BYTES; i++) begin
      if (i < int'(nbytes)) width_mask[i] = 1'b1;
    end
    // Natural alignment: low offset bits inside the access size must be zero.
    misaligned = (nbytes == 0) || ((ofs & OFS_W'(nbytes - 1)) != '0);
    err        = misaligned;
    be         = misaligned ? '0 : (width_mask << ofs);
  end
endmodule

// File: rtl/lsf_store_fmt.sv
module lsf_store_fmt
  import lsf_pkg::*;
#(
  parameter int REG_W = 32,
  localparam int BUS_W = 2 * REG_W
) (
  input  acc_e             acc,
  input  logic [REG_W-1:0] src_lo,
  input  logic [REG_W-1:0] src_hi,
  output logic [BUS_W-1:0] wdata
);
  localparam int N_BYTE = BUS_W / 8;
  localparam int N_HALF = BUS_W / 16;
  localparam int N_WORD = BUS_W / REG_W;

  logic [15:0] half_src;

  always_comb begin
    // Q access takes the upper halfword; plain halfword the lower one.
    half_src = (acc == ACC_QHALF) ? src_lo[REG_W-1 -: 16] : src_lo[15:0];
    wdata    = '0;
    case (acc)
      ACC_BYTE_S, ACC_BYTE_U: begin
        for (int i = 0; i < N_BYTE; i++) wdata[8*i +: 8] = src_lo[7:0];
      end
      ACC_HALF_S, ACC_HALF_U, ACC_QHALF: begin
        for (int i = 0; i < N_HALF; i++) wdata[16*i +: 16] = half_src;
      end
      ACC_WORD: begin
        for (int i = 0; i < N_WORD; i++) wdata[REG_W*i +: REG_W] = src_lo;
      end
      ACC_PAIR: wdata = {src_hi, src_lo};
      default:  wdata = '0;
    endcase
  end
endmodule

// File: rtl/lsf_load_fmt.sv
module lsf_load_fmt
  import lsf_pkg::*;
#(
  parameter int REG_W = 32,
  localparam int BUS_W = 2 * REG_W,
  localparam int OFS_W = $clog2(BUS_W / 8)
) (
  input  acc_e             acc,
  input  logic [OFS_W-1:0] ofs,
  input  logic [BUS_W-1:0] rdata,
  output logic [REG_W-1:0] res_lo,
  output logic [REG_W-1:0] res_hi
);
  logic [REG_W-1:0] aligned;
  logic [7:0]       b0;
  logic [15:0]      h0;

  always_comb begin
    // Bring the addressed lane down to bit 0 (little-endian).
    aligned = REG_W'(rdata >> {ofs, 3'b000});
    b0      = aligned[7:0];
    h0      = aligned[15:0];
    res_lo  = '0;
    res_hi  = '0;
    case (acc)
      ACC_BYTE_S: res_lo = {{(REG_W-8){b0[7]}}, b0};
      ACC_BYTE_U: res_lo = {{(REG_W-8){1'b0}}, b0};
      ACC_HALF_S: res_lo = {{(REG_W-16){h0[15]}}, h0};
      ACC_HALF_U: res_lo = {{(REG_W-16){1'b0}}, h0};
      ACC_QHALF:  res_lo = {h0, {(REG_W-16){1'b0}}};
      ACC_WORD:   res_lo = aligned;
      ACC_PAIR: begin
        res_lo = rdata[REG_W-1:0];
        res_hi = rdata[BUS_W-1:REG_W];
      end
      default: begin
        res_lo = '0;
        res_hi = '0;
      end
    endcase
  end
endmodule

// File: rtl/lsf_formatter.sv
module lsf_formatter
  import lsf_pkg::*;
#(
  parameter int REG_W = 32,
  localparam int BUS_W = 2 * REG_W,
  localparam int BUS_BYTES = BUS_W / 8,
  localparam int OFS_W = $clog2(BUS_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_is_load,
  input  logic [2:0]           req_acc,
  input  logic [OFS_W-1:0]     req_addr_lo,
  input  logic [REG_W-1:0]     req_wdata_lo,
  input  logic [REG_W-1:0]     req_wdata_hi,
  input  logic [BUS_W-1:0]     req_rdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [BUS_BYTES-1:0] rsp_be,
  output logic [BUS_W-1:0]     rsp_wdata,
  output logic [REG_W-1:0]     rsp_ld_lo,
  output logic [REG_W-1:0]     rsp_ld_hi,
  output logic                 rsp_err
);
  acc_e                 acc_in;
  logic [BUS_BYTES-1:0] be_c;
  logic                 err_c;
  logic [BUS_W-1:0]     st_c;
  logic [REG_W-1:0]     ld_lo_c;
  logic [REG_W-1:0]     ld_hi_c;
  logic                 accept;

  acc_e                 acc_q;
  logic                 load_q;

  assign acc_in = acc_e'(req_acc);

  lsf_lane_ctl #(.REG_W(REG_W)) u_lane (
    .acc (acc_in),
    .ofs (req_addr_lo),
    .be  (be_c),
    .err (err_c)
  );

  lsf_store_fmt #(.REG_W(REG_W)) u_st (
    .acc    (acc_in),
    .src_lo (req_wdata_lo),
    .src_hi (req_wdata_hi),
    .wdata  (st_c)
  );

  lsf_load_fmt #(.REG_W(REG_W)) u_ld (
    .acc    (acc_in),
    .ofs    (req_addr_lo),
    .rdata  (req_rdata),
    .res_lo (ld_lo_c),
    .res_hi (ld_hi_c)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_be    <= '0;
      rsp_wdata <= '0;
      rsp_ld_lo <= '0;
      rsp_ld_hi <= '0;
      rsp_err   <= 1'b0;
      acc_q     <= ACC_BYTE_S;
      load_q    <= 1'b0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_be    <= be_c;
        rsp_err   <= err_c;
        rsp_wdata <= (req_is_load || err_c) ? '0 : st_c;
        rsp_ld_lo <= (!req_is_load || err_c) ? '0 : ld_lo_c;
        rsp_ld_hi <= (!req_is_load || err_c) ? '0 : ld_hi_c;
        acc_q     <= acc_in;
        load_q    <= req_is_load;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  AST_ERR_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_be == '0 && rsp_wdata == '0 && rsp_ld_lo == '0); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_be) && $stable(rsp_wdata)
      && $stable(rsp_ld_lo) && $stable(rsp_ld_hi) && $stable(rsp_err)); // R10

  AST_Q_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && load_q && acc_q == ACC_QHALF |-> rsp_ld_lo[15:0] == '0); // R3

  AST_LOAD_NO_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && load_q |-> rsp_wdata == '0); // R9

  AST_LANES_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err |-> $countones(rsp_be) inside {1, 2, 4, 8}); // R5

  AST_PAIR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err && acc_q == ACC_PAIR |-> rsp_be == '1); // R7
endmodule

// File: tb/lsf_formatter_tb.sv
module lsf_formatter_tb;
  typedef struct packed {
    logic [7:0]  be;
    logic [63:0] wdata;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        err;
    logic        ld;
    logic [2:0]  acc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_is_load = 1'b0;
  logic [2:0]  req_acc = '0;
  logic [2:0]  req_addr_lo = '0;
  logic [31:0] req_wdata_lo = '0;
  logic [31:0] req_wdata_hi = '0;
  logic [63:0] req_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [7:0]  rsp_be;
  logic [63:0] rsp_wdata;
  logic [31:0] rsp_ld_lo;
  logic [31:0] rsp_ld_hi;
  logic        rsp_err;

  int   n_chk = 0;
  int   n_bad = 0;
  exp_t q_exp[$];

  always #10 clk = ~clk;

  lsf_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_load(req_is_load), .req_acc(req_acc), .req_addr_lo(req_addr_lo),
    .req_wdata_lo(req_wdata_lo), .req_wdata_hi(req_wdata_hi), .req_rdata(req_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_be(rsp_be), .rsp_wdata(rsp_wdata),
    .rsp_ld_lo(rsp_ld_lo), .rsp_ld_hi(rsp_ld_hi), .rsp_err(rsp_err)
  );

  function automatic exp_t model(logic ld, logic [2:0] acc, logic [2:0] ofs,
                                 logic [31:0] lo, logic [31:0] hi, logic [63:0] rd);
    exp_t e;
    int n;
    logic [63:0] v;
    e = '0;
    e.ld = ld;
    e.acc = acc;
    case (acc)
      3'd0, 3'd1:       n = 1;
      3'd2, 3'd3, 3'd4: n = 2;
      3'd5:             n = 4;
      3'd6:             n = 8;
      default:          n = 0;
    endcase
    if (n == 0 || (int'(ofs) % n) != 0) begin
      e.err = 1'b1;
      return e;
    end
    for (int b = 0; b < 8; b++) e.be[b] = (b >= int'(ofs)) && (b < int'(ofs) + n);
    if (!ld) begin
      for (int b = 0; b < 8; b++) begin
        case (acc)
          3'd0, 3'd1: e.wdata[8*b +: 8] = lo[7:0];
          3'd2, 3'd3: e.wdata[8*b +: 8] = lo[8*(b%2) +: 8];
          3'd4:       e.wdata[8*b +: 8] = lo[16 + 8*(b%2) +: 8];
          3'd5:       e.wdata[8*b +: 8] = lo[8*(b%4) +: 8];
          default:    e.wdata[8*b +: 8] = (b < 4) ? lo[8*b +: 8] : hi[8*(b-4) +: 8];
        endcase
      end
    end else begin
      v = '0;
      for (int k = 0; k < n; k++) v[8*k +: 8] = rd[8*(int'(ofs)+k) +: 8];
      case (acc)
        3'd0: e.lo = {{24{v[7]}}, v[7:0]};
        3'd1: e.lo = {24'h0, v[7:0]};
        3'd2: e.lo = {{16{v[15]}}, v[15:0]};
        3'd3: e.lo = {16'h0, v[15:0]};
        3'd4: e.lo = {v[15:0], 16'h0};
        3'd5: e.lo = v[31:0];
        default: begin
          e.lo = v[31:0];
          e.hi = v[63:32];
        end
      endcase
    end
    return e;
  endfunction

  function automatic string tag_of(exp_t e);
    if (e.err) return "R8";
    if (e.ld) begin
      case (e.acc)
        3'd0, 3'd1: return "R1";
        3'd2, 3'd3: return "R2";
        3'd4:       return "R3";
        default:    return "R4";
      endcase
    end
    case (e.acc)
      3'd4:    return "R6";
      3'd6:    return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(exp_t e);
    string t;
    string t9;
    t  = tag_of(e);
    t9 = e.ld ? "R9" : t;
    chk(t,  "be",    {56'h0, rsp_be}, {56'h0, e.be});
    chk(t,  "err",   {63'h0, rsp_err}, {63'h0, e.err});
    chk(t9, "wdata", rsp_wdata, e.wdata);
    chk(e.ld ? t : "R9", "ld_lo", {32'h0, rsp_ld_lo}, {32'h0, e.lo});
    chk((e.ld && e.acc == 3'd6) ? t : "R9", "ld_hi", {32'h0, rsp_ld_hi}, {32'h0, e.hi});
  endtask

  task automatic set_dir(int i);
    req_valid    = 1'b1;
    req_rdata    = 64'h80F1_7E02_C3A4_5B96;
    req_wdata_lo = 32'hA1B2_C3D4;
    req_wdata_hi = 32'h1122_3344;
    case (i)
      0:  begin req_is_load = 1; req_acc = 0; req_addr_lo = 7; end
      1:  begin req_is_load = 1; req_acc = 1; req_addr_lo = 7; end
      2:  begin req_is_load = 1; req_acc = 2; req_addr_lo = 6; end
      3:  begin req_is_load = 1; req_acc = 3; req_addr_lo = 2; end
      4:  begin req_is_load = 1; req_acc = 4; req_addr_lo = 4; end
      5:  begin req_is_load = 1; req_acc = 5; req_addr_lo = 4; end
      6:  begin req_is_load = 1; req_acc = 6; req_addr_lo = 0; end
      7:  begin req_is_load = 0; req_acc = 0; req_addr_lo = 5; end
      8:  begin req_is_load = 0; req_acc = 3; req_addr_lo = 2; end
      9:  begin req_is_load = 0; req_acc = 4; req_addr_lo = 6; end
      10: begin req_is_load = 0; req_acc = 5; req_addr_lo = 4; end
      11: begin req_is_load = 0; req_acc = 6; req_addr_lo = 0; end
      12: begin req_is_load = 1; req_acc = 2; req_addr_lo = 3; end
      13: begin req_is_load = 0; req_acc = 5; req_addr_lo = 2; end
      14: begin req_is_load = 1; req_acc = 6; req_addr_lo = 4; end
      default: begin req_is_load = 0; req_acc = 7; req_addr_lo = 0; end
    endcase
  endtask

  initial begin
    int   cyc;
    logic stalled;
    logic [200:0] held;
    void'($urandom(32'd4242));
    stalled = 1'b0;
    held    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11", "rsp_valid", {63'h0, rsp_valid}, 64'h0);
    chk("R11", "req_ready", {63'h0, req_ready}, 64'h1);
    for (cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (cyc < 16) begin
        set_dir(cyc);
        rsp_ready = 1'b1;
      end else if (cyc == 16) begin
        req_valid = 1'b0;
      end else begin
        if (!(req_valid && !req_ready)) begin
          req_valid    = ($urandom % 4) != 0;
          req_is_load  = $urandom % 2;
          req_acc      = 3'($urandom);
          req_addr_lo  = ($urandom % 3 == 0) ? 3'($urandom) : 3'(($urandom % 2) * 4);
          req_wdata_lo = $urandom;
          req_wdata_hi = $urandom;
          req_rdata    = {$urandom, $urandom};
        end
        rsp_ready = ($urandom % 3) != 0;
      end
      #1;
      if (stalled) begin
        chk("R10", "stall_hold", {63'h0, rsp_valid}, 64'h1);
        chk("R10", "stall_data", 64'(held != {rsp_be, rsp_wdata, rsp_ld_lo, rsp_ld_hi, rsp_err}), 64'h0);
      end
      chk("R10", "req_ready", {63'h0, req_ready}, {63'h0, (!rsp_valid || rsp_ready)});
      if (rsp_valid && rsp_ready) begin
        if (q_exp.size() == 0) chk("R10", "spurious_rsp", 64'h1, 64'h0);
        else compare(q_exp.pop_front());
      end
      if (req_valid && req_ready)
        q_exp.push_back(model(req_is_load, req_acc, req_addr_lo, req_wdata_lo, req_wdata_hi, req_rdata));
      stalled = rsp_valid && !rsp_ready;
      held    = {rsp_be, rsp_wdata, rsp_ld_lo, rsp_ld_hi, rsp_err};
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule